// File: doc/BRIEF.md
# Linearly Interpolating Cosine Synthesizer

This block is a direct digital synthesis core. Every clock it advances a wide phase accumulator by a programmable tuning word and turns the phase into one signed cosine sample for a digital-to-analog converter. The upper bits of the phase pick an entry in a cosine table generated at elaboration. The lower, fractional bits place the phase between that entry and the next one. The sample is formed by linear interpolation between the two entries and is then rounded down to the converter width.

Software or a control block presents a tuning word and pulses a load strobe. The new word then sets the output frequency without disturbing the running phase. For a sample rate fs, the tuning word for an output frequency fout is round(4096 · fout / fs · 2^32). The output follows the phase after a fixed pipeline latency, and a valid flag marks the first sample computed from a defined phase.

Top module: `dds_lerp_gen`

## Requirements
- R1: The phase accumulator is 44 bits wide: 12 index bits above 32 fractional bits. On every clock it adds the active tuning word and wraps modulo 2^44.
- R2: `tune_i` is captured into the active tuning word only in a cycle where `load_i` is high. Otherwise `tune_i` has no effect. A word captured at clock edge k is first added at edge k+1, and the phase is not cleared by a load.
- R3: While `rst_ni` is low, the phase and the active tuning word are zero, `valid_o` is low and `sample_o` is zero. `sample_o` stays zero for as long as `valid_o` is low.
- R4: After reset is released, `valid_o` rises on the third rising clock edge and then stays high until the next reset.
- R5: The sample presented after edge n belongs to the phase value that the accumulator held after edge n-3.
- R6: The cosine table has 4096 points. Point i holds round(131071 · cos(2π·i/4096)) as an 18-bit signed value. The table is addressed by accumulator bits [43:32].
- R7: The interpolated 18-bit value is the table point plus floor(d · f / 2^32). Here d is the next point minus the current one, with point 0 following point 4095, and f is accumulator bits [31:0].
- R8: The interpolated value is reduced to 12 bits by adding 32, shifting right arithmetically by 6, and clamping to ±2047. This makes `sample_o` exact (+2047, 0, −2047) at phases whose bits [41:0] are zero. At other phases it is within ±2 LSB of 131071/64 · cos(2π·phase/2^44), clamped to ±2047.
- R9: `sample_o` never leaves the range −2047 to +2047.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Captures `tune_i` as the active tuning word |
| tune_i | input | 44 | Tuning word (phase increment per clock) |
| sample_o | output | 12 | Signed cosine sample, two's complement |
| valid_o | output | 1 | High once `sample_o` reflects a defined phase |

## Verification
The assertions assume that `tune_i` only matters while `load_i` is high. They also assume that a non-zero active word always moves the phase, which holds because the word and the accumulator have the same width. The bench drives random words mixed with quarter-turn, half-turn, zero and very slow increments. Between loads it scrambles `tune_i` with `load_i` low. A bench model tracks the phase with modulo-2^44 arithmetic, so wraps and ignored words are judged against a phase computed independently of the design. Every sample is compared against a real-valued cosine of that phase.

// File: rtl/dds_lerp_pkg.sv
package dds_lerp_pkg;
  localparam real TWO_PI = 6.283185307179586;

  // Round half away from zero.
  function automatic int round_away(input real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

  function automatic int cos_point(input int k, input int npts, input int amp);
    return round_away($cos(TWO_PI * real'(k) / real'(npts)) * real'(amp));
  endfunction
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PH_W = 44
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [PH_W-1:0] tune_i,
  output logic [PH_W-1:0] tw_o,
  output logic [PH_W-1:0] phase_o
);
  logic [PH_W-1:0] tw_q, acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tw_q  <= '0;
      acc_q <= '0;
    end else begin
      acc_q <= acc_q + tw_q;  // wraps modulo 2^PH_W
      if (load_i) tw_q <= tune_i;
    end
  end

  assign tw_o    = tw_q;
  assign phase_o = acc_q;
endmodule

// File: rtl/dds_cos_lut.sv
module dds_cos_lut
  import dds_lerp_pkg::*;
#(
  parameter int IDX_W  = 12,
  parameter int FRAC_W = 32,
  parameter int TBL_W  = 18
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [IDX_W+FRAC_W-1:0] phase_i,
  output logic signed [TBL_W-1:0] point_o,
  output logic signed [TBL_W:0]   diff_o,
  output logic [FRAC_W-1:0]       frac_o
);
  localparam int NPTS = 2 ** IDX_W;
  localparam int QW   = IDX_W - 2;
  localparam int QN   = 2 ** QW;
  localparam int AMP  = 2 ** (TBL_W - 1) - 1;

  // Quarter wave, QN+1 points covering 0..pi/2 inclusive.
  logic signed [TBL_W-1:0] rom [QN+1];

  initial begin
    for (int k = 0; k <= QN; k++) rom[k] = TBL_W'(cos_point(k, NPTS, AMP));
  end

  logic [IDX_W-1:0] idx [2];
  logic signed [TBL_W-1:0] val [2];

  assign idx[0] = phase_i[FRAC_W +: IDX_W];
  assign idx[1] = idx[0] + IDX_W'(1);  // successor wraps to point 0

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [1:0]    quad;
    logic [QW-1:0] k;
    logic [QW:0]   addr;
    logic signed [TBL_W-1:0] raw;
    assign quad = idx[p][IDX_W-1 -: 2];
    assign k    = idx[p][QW-1:0];
    assign addr = quad[0] ? ((QW+1)'(QN) - {1'b0, k}) : {1'b0, k};
    assign raw  = rom[addr];
    assign val[p] = (quad[0] ^ quad[1]) ? -raw : raw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      point_o <= '0;
      diff_o  <= '0;
      frac_o  <= '0;
    end else begin
      point_o <= val[0];
      diff_o  <= {val[1][TBL_W-1], val[1]} - {val[0][TBL_W-1], val[0]};
      frac_o  <= phase_i[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/dds_interp.sv
module dds_interp #(
  parameter int FRAC_W = 32,
  parameter int TBL_W  = 18,
  parameter int OUT_W  = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [TBL_W-1:0] point_i,
  input  logic signed [TBL_W:0]   diff_i,
  input  logic [FRAC_W-1:0]       frac_i,
  output logic signed [OUT_W-1:0] sample_o
);
  localparam int PW   = TBL_W + FRAC_W + 2;
  localparam int SH   = TBL_W - OUT_W;
  localparam int QW   = TBL_W + 2 - SH;
  localparam int MAXV = 2 ** (OUT_W - 1) - 1;

  // Stage 2: multiply.
  logic signed [PW-1:0] prod_c;
  assign prod_c = PW'(diff_i) * PW'($signed({1'b0, frac_i}));

  logic signed [TBL_W-1:0] point_q;
  logic signed [TBL_W:0]   step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      point_q <= '0;
      step_q  <= '0;
    end else begin
      point_q <= point_i;
      step_q  <= prod_c[FRAC_W +: TBL_W+1];  // floor division by 2^FRAC_W
    end
  end

  // Stage 3: add, round, clamp.
  logic signed [TBL_W+1:0] sum_c, rnd_c;
  logic signed [QW-1:0]    q_c;
  logic signed [OUT_W-1:0] sat_c;

  always_comb begin
    sum_c = {{2{point_q[TBL_W-1]}}, point_q} + {step_q[TBL_W], step_q};
    rnd_c = sum_c + (TBL_W+2)'(2 ** (SH - 1));
    q_c   = rnd_c[TBL_W+1:SH];
    if (q_c > QW'(MAXV))       sat_c = OUT_W'(MAXV);
    else if (q_c < -QW'(MAXV)) sat_c = -OUT_W'(MAXV);
    else                       sat_c = q_c[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sample_o <= '0;
    else         sample_o <= sat_c;
  end
endmodule

// File: rtl/dds_lerp_gen.sv
module dds_lerp_gen #(
  parameter int IDX_W  = 12,
  parameter int FRAC_W = 32,
  parameter int TBL_W  = 18,
  parameter int OUT_W  = 12,
  localparam int PH_W  = IDX_W + FRAC_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [PH_W-1:0]         tune_i,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    valid_o
);
  localparam int LAT = 3;

  logic [PH_W-1:0]         tw_q, acc_q;
  logic signed [TBL_W-1:0] point_q;
  logic signed [TBL_W:0]   diff_q;
  logic [FRAC_W-1:0]       frac_q;
  logic [LAT-1:0]          vld_q;

  dds_phase_acc #(.PH_W(PH_W)) i_acc (
    .clk_i, .rst_ni, .load_i, .tune_i,
    .tw_o(tw_q), .phase_o(acc_q)
  );

  dds_cos_lut #(.IDX_W(IDX_W), .FRAC_W(FRAC_W), .TBL_W(TBL_W)) i_lut (
    .clk_i, .rst_ni, .phase_i(acc_q),
    .point_o(point_q), .diff_o(diff_q), .frac_o(frac_q)
  );

  dds_interp #(.FRAC_W(FRAC_W), .TBL_W(TBL_W), .OUT_W(OUT_W)) i_interp (
    .clk_i, .rst_ni, .point_i(point_q), .diff_i(diff_q), .frac_i(frac_q),
    .sample_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[LAT-2:0], 1'b1};
  end

  assign valid_o = vld_q[LAT-1];
endmodule

// File: rtl/dds_lerp_chk.sv
module dds_lerp_chk #(
  parameter int PH_W  = 44,
  parameter int OUT_W = 12
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    load_i,
  input logic [PH_W-1:0]         tw_q,
  input logic [PH_W-1:0]         acc_q,
  input logic                    valid_o,
  input logic signed [OUT_W-1:0] sample_o
);
  localparam int MAXV = 2 ** (OUT_W - 1) - 1;

  assert_tw_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(tw_q));

  assert_zero_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tw_q == '0) |=> $stable(acc_q));

  assert_phase_moves_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tw_q != '0) |=> !$stable(acc_q));

  assert_valid_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  assert_idle_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (sample_o == '0));

  assert_in_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o <= MAXV) && (sample_o >= -MAXV));
endmodule

bind dds_lerp_gen dds_lerp_chk #(.PH_W(PH_W), .OUT_W(OUT_W)) i_chk (.*);

// File: tb/test_dds_lerp_gen.sv
module test_dds_lerp_gen;
  localparam int PH_W = 44;
  localparam real PI2 = 6.283185307179586;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic load_i = 1'b0;
  logic [PH_W-1:0] tune_i = '0;
  logic signed [11:0] sample_o;
  logic valid_o;

  int n_chk = 0, n_err = 0;
  logic [PH_W-1:0] m_acc, m_tw;
  logic [PH_W-1:0] hist [4];
  int since_rst;

  always #4 clk_i = ~clk_i;

  dds_lerp_gen i_dds_lerp_gen (.*);

  function automatic int ref_val(input logic [PH_W-1:0] ph);
    real a;
    int r;
    a = $cos(PI2 * real'(ph) / 17592186044416.0) * 131071.0 / 64.0;
    r = (a >= 0.0) ? $rtoi(a + 0.5) : -$rtoi(-a + 0.5);
    if (r > 2047) r = 2047;
    if (r < -2047) r = -2047;
    return r;
  endfunction

  task automatic fail(input string req, input int act, input int exp);
    n_err++;
    $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
  endtask

  task automatic model_reset();
    m_acc = '0;
    m_tw = '0;
    for (int i = 0; i < 4; i++) hist[i] = '0;
    since_rst = 0;
  endtask

  // Compare valid and sample against the model (R4, R5, R6, R7, R8).
  task automatic chk_out(input string req);
    logic exp_v;
    int e, d;
    exp_v = (since_rst >= 3);
    n_chk++;
    if (valid_o !== exp_v) begin
      fail({req, "/R4 valid"}, int'(valid_o), int'(exp_v));
      return;
    end
    if (!exp_v) begin
      if (sample_o !== 12'sd0) fail({req, "/R3 idle"}, int'(sample_o), 0);
      return;
    end
    e = ref_val(hist[3]);
    d = int'(sample_o) - e;
    if (hist[3][41:0] == '0) begin
      if (d != 0) fail({req, "/R8 exact"}, int'(sample_o), e);
    end else if (d > 2 || d < -2) begin
      fail({req, "/R7 tolerance"}, int'(sample_o), e);
    end
  endtask

  // Drive at negedge, let one rising edge pass, update model, check.
  task automatic tick(input logic ld, input logic [PH_W-1:0] tw, input string req);
    load_i = ld;
    tune_i = tw;
    @(posedge clk_i);
    @(negedge clk_i);
    m_acc = m_acc + m_tw;
    if (ld) m_tw = tw;
    hist[3] = hist[2];
    hist[2] = hist[1];
    hist[1] = hist[0];
    hist[0] = m_acc;
    since_rst++;
    chk_out(req);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    load_i = 1'b0;
    #1;
    n_chk++;  // R3: asynchronous clear
    if (valid_o !== 1'b0 || sample_o !== 12'sd0)
      fail("R3 reset", int'(sample_o), 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    model_reset();
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [PH_W-1:0] tw;
    int seed;
    seed = $urandom(32'h5EED1);
    model_reset();
    repeat (2) @(negedge clk_i);
    n_chk++;
    if (valid_o !== 1'b0 || sample_o !== 12'sd0) fail("R3 power-up", int'(sample_o), 0);
    rst_ni = 1'b1;

    // R3/R4/R8: zero word holds phase 0, clamp gives +2047 after latency.
    for (int i = 0; i < 6; i++) tick(1'b0, '0, "R4_latency");

    // R2/R5: half turn per clock, load takes effect one edge later.
    tick(1'b1, 44'h800_0000_0000, "R2_load_half");
    for (int i = 0; i < 8; i++) tick(1'b0, 44'h123_4567_89AB, "R2_ignore");

    // R6: quarter turn gives +2047, 0, -2047, 0 exactly.
    tick(1'b1, 44'h400_0000_0000, "R6_quarter");
    for (int i = 0; i < 10; i++) tick(1'b0, '0, "R6_quarter");

    // R7: very slow sweep across entries (fraction dominates).
    tick(1'b1, 44'h000_1234_5678, "R7_slow");
    for (int i = 0; i < 300; i++) tick(1'b0, 44'hFFF_FFFF_FFFF, "R7_slow");

    // R3: reset mid-run clears phase and word.
    do_reset();
    for (int i = 0; i < 5; i++) tick(1'b0, 44'h7FF_0000_0001, "R3_rerun");

    // R1/R2/R9: random words, wrap-around, tune_i scrambled between loads.
    for (int b = 0; b < 60; b++) begin
      tw = {$urandom, $urandom} & 64'h0000_0FFF_FFFF_FFFF;
      if (b % 4 == 1) tw = tw >> ($urandom % 30 + 10);
      if (b % 7 == 3) tw = 44'hFFF_FFFF_FFFF;  // step of -1: backward wrap
      tick(1'b1, tw, "R1_random");
      for (int i = 0; i < 40; i++)
        tick(1'b0, {$urandom, $urandom} & 64'h0000_0FFF_FFFF_FFFF, "R2_random");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule